// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block drives the multiplexed external memory bus of an 8-bit microcontroller. A free-running machine cycle of six states sets the timing. Each state lasts two oscillator clocks in the 12-clock mode and one clock in the 6-clock mode. Each machine cycle is either a fetch cycle or a data cycle. A fetch cycle reads two code bytes, at the program counter and at the program counter plus one. A data cycle performs one data-memory read or write. For every state the sequencer produces the address-latch strobe, the active-low program-store, read and write strobes, and the values and output enables for port 0 and port 2.

The block samples all of its control inputs on the clock edge that starts a machine cycle and holds them for the whole cycle. These inputs are the program counter, the data request with its direction, address width, address and write data, the port 2 register, the internal-memory enable and the strobe-disable bit. The block sends a fetch byte to external memory when the internal-memory enable is low, or when the byte address lies above the on-chip memory size. It serves every other fetch byte internally, with no program-store strobe. The reset input only takes effect after it has been high for two full machine cycles. A shorter pulse leaves the sequence untouched.

Top module: `xbus_sequencer`

## Requirements
- R1: In a fetch cycle, `ale` is high during states 0 and 3 of the six states (counted from 0). This gives two pulses per machine cycle. A machine cycle lasts 12 clocks when `clk6_sel` was low at reset and 6 clocks when it was high, so each state is 2 clocks or 1 clock.
- R2: A data cycle is started by `dreq`=1. In a data cycle `ale` is high only in state 0, and the state 3 pulse is omitted. This holds whatever the value of `ale_off`.
- R3: With `ale_off`=1, `ale` stays low for the whole of a fetch cycle.
- R4: `psen_n` is low in states 1, 2 and 4, 5 when the byte fetched in that half is external. It is high in states 0 and 3, for internal bytes, in data cycles and in reset.
- R5: States 0 to 2 fetch the byte at `pc`, and states 3 to 5 fetch the byte at `pc`+1 (16-bit wrap). A byte is external when `int_rom_en`=0 or when its address is at least ROM_KB*1024. Each of the two bytes is decided separately.
- R6: In a data cycle, `rd_n` (when `dwr`=0) or `wr_n` (when `dwr`=1) is low in states 2 to 4 only. It is never low together with `psen_n` or with the other strobe.
- R7: During a data cycle `p2_oe`=1. `p2_out` is then `daddr[15:8]` when `dwide`=1 and the sampled `p2_reg` when `dwide`=0. For an external fetch byte, `p2_out` is the high byte of that byte's address with `p2_oe`=1. Otherwise `p2_out` is the sampled `p2_reg` with `p2_oe`=0.
- R8: `p0_out` carries the low address byte with `p0_oe`=1 in state 0 of a data cycle and in the lead state (0 or 3) of an external fetch byte. For a write, `p0_out` then carries `dwdata` with `p0_oe`=1 in states 1 to 5. In all other states `p0_oe`=0 and `p0_out`=8'hFF.
- R9: Once `rst_in` has been high for two machine cycles, all outputs are idle from the next clock: `ale`=0, all strobes high, both enables 0, and both ports 8'hFF. `clk6_sel` is latched in this state. On the first clock after `rst_in` falls, the outputs show state 0 of a new machine cycle.
- R10: A pulse on `rst_in` that is shorter than two machine cycles does not change the outputs or the cycle position.
- R11: The inputs are sampled only on the clock edge that starts a machine cycle. Changing them at any other edge has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Reset request, high for two machine cycles to reset |
| clk6_sel | input | 1 | 1 = 6 clocks per machine cycle, 0 = 12; latched in reset |
| pc | input | 16 | Program counter of the next fetch pair |
| int_rom_en | input | 1 | 1 = low addresses are served internally |
| ale_off | input | 1 | Suppress ALE in fetch cycles |
| dreq | input | 1 | Next machine cycle is a data-memory access |
| dwr | input | 1 | Data access is a write |
| dwide | input | 1 | Data access uses a 16-bit address |
| daddr | input | 16 | Data access address |
| dwdata | input | 8 | Write data byte |
| p2_reg | input | 8 | Port 2 register contents |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 drive value |
| p0_oe | output | 1 | Port 0 strong drive enable |
| p2_out | output | 8 | Port 2 drive value |
| p2_oe | output | 1 | Port 2 bus drive enable |

## Verification
The hardest case to produce is a fetch pair whose two bytes fall on opposite sides of the on-chip boundary. Reaching it needs a program counter exactly one below the boundary, or at the top of the address space where the second address wraps to zero. Only then does a single cycle show one internal and one external half. Directed cycles place the counter on these values, with the internal-memory enable both high and low. Random cycles also bias the counter toward the boundary. Sub-threshold reset pulses are placed inside running cycles, and all inputs are scrambled on every clock except the cycle-start edge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int STATES   = 6;
  localparam int PHASES   = 2;
  localparam int FETCHES  = 2;
  localparam int AW       = 16;
  localparam int DW       = 8;
  localparam int RST_MC   = 2;
  localparam int HALF     = STATES / FETCHES;
  localparam int STB_FIRST = 2;
  localparam int STB_LAST  = 4;
  localparam int TW = $clog2(STATES * PHASES);
  localparam int SW = $clog2(STATES);

  typedef struct packed {
    logic                          dreq;
    logic                          dwr;
    logic                          dwide;
    logic                          ale_off;
    logic [AW-1:0]                 daddr;
    logic [DW-1:0]                 dwdata;
    logic [DW-1:0]                 p2;
    logic [FETCHES-1:0]            ext;
    logic [FETCHES-1:0][AW-1:0]    faddr;
  } xctx_t;

  typedef struct packed {
    logic          ale;
    logic          psen_n;
    logic          rd_n;
    logic          wr_n;
    logic          p0_oe;
    logic          p2_oe;
    logic [DW-1:0] p0;
    logic [DW-1:0] p2;
  } xpins_t;

  localparam xpins_t PINS_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                   p0_oe: 1'b0, p2_oe: 1'b0, p0: '1, p2: '1};
endpackage

// File: rtl/xbus_reset_filter.sv
module xbus_reset_filter
  import xbus_pkg::*;
(
  input  logic clk,
  input  logic rst_in,
  input  logic mode6_live,
  output logic rst_q
);
  localparam int MAXCLK = RST_MC * STATES * PHASES;
  localparam int CW = $clog2(MAXCLK + 1);
  localparam logic [CW-1:0] NEED12 = CW'(RST_MC * STATES * PHASES);
  localparam logic [CW-1:0] NEED6  = CW'(RST_MC * STATES);

  logic [CW-1:0] cnt;
  logic [CW-1:0] need;

  assign need = mode6_live ? NEED6 : NEED12;

  always_ff @(posedge clk) begin
    if (!rst_in)
      cnt <= '0;
    else if (cnt < need)
      cnt <= cnt + 1'b1;
  end

  assign rst_q = rst_in && (cnt >= need);
endmodule

// File: rtl/xbus_state_timer.sv
module xbus_state_timer
  import xbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          mode6,
  output logic [TW-1:0] tick_nxt,
  output logic          cyc_start
);
  localparam logic [TW-1:0] LAST12 = TW'(STATES * PHASES - 1);
  localparam logic [TW-1:0] LAST6  = TW'(STATES - 1);

  logic [TW-1:0] tick;
  logic [TW-1:0] last;

  assign last      = mode6 ? LAST6 : LAST12;
  assign tick_nxt  = (tick >= last) ? '0 : tick + 1'b1;
  assign cyc_start = (tick_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      tick <= '1;
    else
      tick <= tick_nxt;
  end
endmodule

// File: rtl/xbus_cycle_ctx.sv
module xbus_cycle_ctx
  import xbus_pkg::*;
#(
  parameter int ROM_KB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_start,
  input  logic [AW-1:0] pc,
  input  logic          int_rom_en,
  input  logic          ale_off,
  input  logic          dreq,
  input  logic          dwr,
  input  logic          dwide,
  input  logic [AW-1:0] daddr,
  input  logic [DW-1:0] dwdata,
  input  logic [DW-1:0] p2_reg,
  output xctx_t         ctx_nxt
);
  localparam int ROM_BYTES = ROM_KB * 1024;
  localparam logic [AW:0] ROM_TOP = (AW+1)'(ROM_BYTES);

  xctx_t ctx_q;
  xctx_t cap;

  for (genvar i = 0; i < FETCHES; i++) begin : g_fetch
    assign cap.faddr[i] = pc + AW'(i);
    assign cap.ext[i]   = !int_rom_en || ({1'b0, cap.faddr[i]} >= ROM_TOP);
  end

  assign cap.dreq    = dreq;
  assign cap.dwr     = dwr;
  assign cap.dwide   = dwide;
  assign cap.ale_off = ale_off;
  assign cap.daddr   = daddr;
  assign cap.dwdata  = dwdata;
  assign cap.p2      = p2_reg;

  assign ctx_nxt = cyc_start ? cap : ctx_q;

  always_ff @(posedge clk) begin
    if (rst)
      ctx_q <= '0;
    else
      ctx_q <= ctx_nxt;
  end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          mode6,
  input  logic [TW-1:0] tick_nxt,
  input  xctx_t         ctx_nxt,
  output xpins_t        pins
);
  logic [SW-1:0] st;
  logic          upper;
  logic          lead;
  logic [AW-1:0] fa;
  logic          fext;
  logic          in_stb;
  xpins_t        nxt;

  always_comb begin
    st     = mode6 ? SW'(tick_nxt) : SW'(tick_nxt >> 1);
    upper  = (st >= SW'(HALF));
    lead   = (st == '0) || (st == SW'(HALF));
    fa     = ctx_nxt.faddr[upper];
    fext   = ctx_nxt.ext[upper];
    in_stb = (st >= SW'(STB_FIRST)) && (st <= SW'(STB_LAST));

    nxt        = PINS_IDLE;
    nxt.p2     = ctx_nxt.p2;

    if (ctx_nxt.dreq) begin
      nxt.ale   = (st == '0);
      nxt.p2_oe = 1'b1;
      nxt.p2    = ctx_nxt.dwide ? ctx_nxt.daddr[AW-1:DW] : ctx_nxt.p2;
      if (st == '0) begin
        nxt.p0    = ctx_nxt.daddr[DW-1:0];
        nxt.p0_oe = 1'b1;
      end else if (ctx_nxt.dwr) begin
        nxt.p0    = ctx_nxt.dwdata;
        nxt.p0_oe = 1'b1;
      end
      if (in_stb) begin
        nxt.rd_n = ctx_nxt.dwr;
        nxt.wr_n = !ctx_nxt.dwr;
      end
    end else begin
      nxt.ale = lead && !ctx_nxt.ale_off;
      if (fext) begin
        nxt.p2_oe = 1'b1;
        nxt.p2    = fa[AW-1:DW];
        if (lead) begin
          nxt.p0    = fa[DW-1:0];
          nxt.p0_oe = 1'b1;
        end else begin
          nxt.psen_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pins <= PINS_IDLE;
    else
      pins <= nxt;
  end
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int ROM_KB = 8
) (
  input  logic          clk,
  input  logic          rst_in,
  input  logic          clk6_sel,
  input  logic [15:0]   pc,
  input  logic          int_rom_en,
  input  logic          ale_off,
  input  logic          dreq,
  input  logic          dwr,
  input  logic          dwide,
  input  logic [15:0]   daddr,
  input  logic [7:0]    dwdata,
  input  logic [7:0]    p2_reg,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [7:0]    p0_out,
  output logic          p0_oe,
  output logic [7:0]    p2_out,
  output logic          p2_oe
);
  logic          rst_q;
  logic          mode6_q;
  logic [TW-1:0] tick_nxt;
  logic          cyc_start;
  xctx_t         ctx_nxt;
  xpins_t        pins;

  xbus_reset_filter u_rst (
    .clk        (clk),
    .rst_in     (rst_in),
    .mode6_live (clk6_sel),
    .rst_q      (rst_q)
  );

  always_ff @(posedge clk) begin
    if (rst_q)
      mode6_q <= clk6_sel;
  end

  xbus_state_timer u_tmr (
    .clk       (clk),
    .rst       (rst_q),
    .mode6     (mode6_q),
    .tick_nxt  (tick_nxt),
    .cyc_start (cyc_start)
  );

  xbus_cycle_ctx #(.ROM_KB(ROM_KB)) u_ctx (
    .clk        (clk),
    .rst        (rst_q),
    .cyc_start  (cyc_start),
    .pc         (pc),
    .int_rom_en (int_rom_en),
    .ale_off    (ale_off),
    .dreq       (dreq),
    .dwr        (dwr),
    .dwide      (dwide),
    .daddr      (daddr),
    .dwdata     (dwdata),
    .p2_reg     (p2_reg),
    .ctx_nxt    (ctx_nxt)
  );

  xbus_strobe_gen u_stb (
    .clk      (clk),
    .rst      (rst_q),
    .mode6    (mode6_q),
    .tick_nxt (tick_nxt),
    .ctx_nxt  (ctx_nxt),
    .pins     (pins)
  );

  assign ale    = pins.ale;
  assign psen_n = pins.psen_n;
  assign rd_n   = pins.rd_n;
  assign wr_n   = pins.wr_n;
  assign p0_out = pins.p0;
  assign p0_oe  = pins.p0_oe;
  assign p2_out = pins.p2;
  assign p2_oe  = pins.p2_oe;
endmodule

// File: rtl/xbus_sequencer_chk.sv
module xbus_sequencer_chk (
  input logic clk,
  input logic rst_in,
  input logic rst_q,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic p0_oe,
  input logic p2_oe
);
  a_r6_no_strobe_overlap: assert property (@(posedge clk) disable iff (rst_in)
    !rd_n || !wr_n |-> psen_n && (rd_n || wr_n));

  a_r2_no_ale_in_data_strobe: assert property (@(posedge clk) disable iff (rst_in)
    !rd_n || !wr_n |-> !ale);

  a_r8_p0_released_for_code: assert property (@(posedge clk) disable iff (rst_in)
    !psen_n |-> !p0_oe);

  a_r8_p0_drives_write_data: assert property (@(posedge clk) disable iff (rst_in)
    !wr_n |-> p0_oe);

  a_r7_p2_drives_in_data: assert property (@(posedge clk) disable iff (rst_in)
    !rd_n || !wr_n |-> p2_oe);

  a_r9_idle_after_reset: assert property (@(posedge clk)
    rst_q |=> !ale && psen_n && rd_n && wr_n && !p0_oe && !p2_oe);
endmodule

bind xbus_sequencer xbus_sequencer_chk u_chk (
  .clk    (clk),
  .rst_in (rst_in),
  .rst_q  (rst_q),
  .ale    (ale),
  .psen_n (psen_n),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .p0_oe  (p0_oe),
  .p2_oe  (p2_oe)
);

// File: tb/xbus_sequencer_test.sv
`timescale 1ns/1ps
module xbus_sequencer_test;
  localparam int ROM_KB = 8;
  localparam int ROM_BYTES = ROM_KB * 1024;

  typedef struct packed {
    logic ale, psen_n, rd_n, wr_n, p0_oe, p2_oe;
    logic [7:0] p0, p2;
  } pins_t;

  logic clk = 1'b0;
  logic rst_in = 1'b1;
  logic clk6_sel = 1'b0;
  logic [15:0] pc = '0, daddr = '0;
  logic int_rom_en = 1'b1, ale_off = 1'b0, dreq = 1'b0, dwr = 1'b0, dwide = 1'b0;
  logic [7:0] dwdata = '0, p2_reg = '0;
  logic ale, psen_n, rd_n, wr_n, p0_oe, p2_oe;
  logic [7:0] p0_out, p2_out;

  int total = 0;
  int bad = 0;
  bit mode6 = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xbus_sequencer #(.ROM_KB(ROM_KB)) uut (
    .clk(clk), .rst_in(rst_in), .clk6_sel(clk6_sel), .pc(pc), .int_rom_en(int_rom_en),
    .ale_off(ale_off), .dreq(dreq), .dwr(dwr), .dwide(dwide), .daddr(daddr),
    .dwdata(dwdata), .p2_reg(p2_reg), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .p2_oe(p2_oe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_ext(input logic [15:0] a, input logic en);
    return !en || (int'(a) >= ROM_BYTES);
  endfunction

  function automatic pins_t expect_pins(input int st, input logic [15:0] pcv,
      input logic en, aoff, dq, wr, wide, input logic [15:0] da,
      input logic [7:0] wd, p2v);
    pins_t e;
    logic [15:0] a;
    bit lead;
    e = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, p0_oe: 1'b0, p2_oe: 1'b0,
          p0: 8'hFF, p2: p2v};
    lead = (st == 0) || (st == 3);
    if (dq) begin
      e.ale = (st == 0);
      e.p2_oe = 1'b1;
      e.p2 = wide ? da[15:8] : p2v;
      if (st == 0) begin e.p0 = da[7:0]; e.p0_oe = 1'b1; end
      else if (wr) begin e.p0 = wd; e.p0_oe = 1'b1; end
      if (st >= 2 && st <= 4) begin
        if (wr) e.wr_n = 1'b0; else e.rd_n = 1'b0;
      end
    end else begin
      a = (st < 3) ? pcv : pcv + 16'd1;
      e.ale = lead && !aoff;
      if (is_ext(a, en)) begin
        e.p2_oe = 1'b1;
        e.p2 = a[15:8];
        if (lead) begin e.p0 = a[7:0]; e.p0_oe = 1'b1; end
        else e.psen_n = 1'b0;
      end
    end
    return e;
  endfunction

  task automatic run_cycle(input logic [15:0] pcv, input logic en, aoff, dq, wr, wide,
      input logic [15:0] da, input logic [7:0] wd, p2v, input bit glitch,
      input bit churn, input string tag_ovr);
    int per;
    int ale_slots;
    int psen_slots;
    int exp_ale;
    int exp_psen;
    pins_t e;
    string ta;
    string tp;
    per = mode6 ? 6 : 12;
    ale_slots = 0;
    psen_slots = 0;
    for (int k = 0; k < per; k++) begin
      if (k == 0) begin
        pc = pcv; int_rom_en = en; ale_off = aoff; dreq = dq; dwr = wr; dwide = wide;
        daddr = da; dwdata = wd; p2_reg = p2v;
      end else if (churn) begin
        pc = 16'($urandom); int_rom_en = 1'($urandom); ale_off = 1'($urandom);
        dreq = 1'($urandom); dwr = 1'($urandom); dwide = 1'($urandom);
        daddr = 16'($urandom); dwdata = 8'($urandom); p2_reg = 8'($urandom);
      end
      rst_in = glitch && (k >= 1) && (k <= 4);
      @(posedge clk);
      @(negedge clk);
      e = expect_pins(mode6 ? k : k / 2, pcv, en, aoff, dq, wr, wide, da, wd, p2v);
      ta = dq ? "R2" : (aoff ? "R3" : "R1");
      tp = "R4";
      if (tag_ovr != "") begin ta = tag_ovr; tp = tag_ovr; end
      check(ale === e.ale, ta, "ale", 32'(ale), 32'(e.ale));
      check(psen_n === e.psen_n, tp, "psen_n", 32'(psen_n), 32'(e.psen_n));
      check({rd_n, wr_n} === {e.rd_n, e.wr_n}, (tag_ovr != "") ? tag_ovr : "R6",
            "rd_n/wr_n", 32'({rd_n, wr_n}), 32'({e.rd_n, e.wr_n}));
      check({p0_oe, p0_out} === {e.p0_oe, e.p0}, (tag_ovr != "") ? tag_ovr : "R8",
            "p0", 32'({p0_oe, p0_out}), 32'({e.p0_oe, e.p0}));
      check({p2_oe, p2_out} === {e.p2_oe, e.p2}, (tag_ovr != "") ? tag_ovr : "R7",
            "p2", 32'({p2_oe, p2_out}), 32'({e.p2_oe, e.p2}));
      if (ale) ale_slots++;
      if (!psen_n) psen_slots++;
    end
    rst_in = 1'b0;
    exp_ale = (dq ? 1 : (aoff ? 0 : 2)) * (mode6 ? 1 : 2);
    exp_psen = dq ? 0 : ((is_ext(pcv, en) ? 2 : 0) + (is_ext(pcv + 16'd1, en) ? 2 : 0));
    exp_psen = exp_psen * (mode6 ? 1 : 2);
    check(ale_slots == exp_ale, "R1", "ale high clocks per cycle", 32'(ale_slots), 32'(exp_ale));
    check(psen_slots == exp_psen, "R5", "psen low clocks per cycle", 32'(psen_slots), 32'(exp_psen));
  endtask

  task automatic do_reset(input bit m6);
    int per;
    clk6_sel = m6;
    rst_in = 1'b1;
    per = m6 ? 6 : 12;
    repeat (2 * per + 3) @(negedge clk);
    check(ale === 1'b0 && psen_n === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1,
          "R9", "strobes idle in reset", 32'({ale, psen_n, rd_n, wr_n}), 32'(4'b0111));
    check({p0_oe, p0_out, p2_oe, p2_out} === {1'b0, 8'hFF, 1'b0, 8'hFF}, "R9",
          "ports idle in reset", 32'({p0_oe, p0_out, p2_oe, p2_out}), 32'({1'b0, 8'hFF, 1'b0, 8'hFF}));
    mode6 = m6;
    rst_in = 1'b0;
  endtask

  task automatic random_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] pcv;
      pcv = ($urandom % 3 == 0) ? 16'(ROM_BYTES - 2 + ($urandom % 4)) : 16'($urandom);
      run_cycle(pcv, 1'($urandom), ($urandom % 5 == 0), ($urandom % 4 == 0), 1'($urandom),
                1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                ($urandom % 16 == 0), 1'b1, "");
    end
  endtask

  task automatic directed_set;
    // R5: boundary split, both orders, and enable low
    run_cycle(16'(ROM_BYTES - 1), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'h5A, 1'b0, 1'b0, "R5");
    run_cycle(16'(ROM_BYTES - 2), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'h5A, 1'b0, 1'b0, "R5");
    run_cycle(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'hC3, 1'b0, 1'b0, "R5");
    run_cycle(16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'hC3, 1'b0, 1'b0, "R5");
    // R3 fetch with strobe disabled, R2 data cycle ignores the disable
    run_cycle(16'hE000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'h11, 1'b0, 1'b0, "R3");
    run_cycle(16'hE000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hA55A, 8'h0, 8'h11, 1'b0, 1'b0, "R2");
    // R7 narrow read and wide write, R6 strobes
    run_cycle(16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1234, 8'h77, 8'h9C, 1'b0, 1'b0, "R7");
    run_cycle(16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'hBEEF, 8'h3D, 8'h9C, 1'b0, 1'b0, "R6");
    // R10 short reset pulse inside a data cycle and a fetch cycle
    run_cycle(16'hF0F0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h4321, 8'hA1, 8'h66, 1'b1, 1'b1, "R10");
    run_cycle(16'hF0F0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'h66, 1'b1, 1'b1, "R10");
    // R11 inputs scrambled mid cycle
    run_cycle(16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'h42, 1'b0, 1'b1, "R11");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(1'b0);
    // R9: first cycle after release starts at state 0
    run_cycle(16'hF000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 8'h00, 1'b0, 1'b0, "R9");
    directed_set();
    random_cycles(300);
    do_reset(1'b1);
    run_cycle(16'hF000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h2468, 8'h0, 8'h00, 1'b0, 1'b0, "R9");
    directed_set();
    random_cycles(300);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule